// File: doc/BRIEF.md
# Reloadable Down-Counting Timer with Prescaler

This block is a programmable down counter for a small controller. Software loads a reload value into a buffer over a byte-wide register bus, picks a count source, and sets an enable bit. The count source is either the internal clock through a divider of 1, 2, 4, 8 or 16, or an external clock pin. While enabled, the counter steps down once per selected tick. The step below zero is the underflow. At that step the counter takes the buffer value again, sets a sticky underflow flag and, if the neighbouring interrupt-enable input is high, drives the interrupt request.

The width is a parameter, 8 or 16 bits. A 16-bit timer has separate low and high buffer bytes. The buffer addresses are two-sided. A write always updates the buffer. While the timer is stopped, the written byte is also copied straight into the counter. A read returns the live count, never the buffer.

The register bus is a plain single-cycle strobe with a combinational read. It carries control traffic only, so it has no valid/ready handshake and never applies back-pressure.

Top module: `tmr_reload_top`

## Requirements
- R1: With the enable bit set, the count drops by exactly one per selected tick. With the enable bit clear, the count holds its value.
- R2: An underflow sets the underflow flag. While `irq_en` is high, `irq` is high whenever the flag is set. While `irq_en` is low, `irq` is low.
- R3: When a tick arrives with the count at zero, the counter reloads from the buffer instead of wrapping to all-ones.
- R4: Writing the control register with bit 7 set while the timer is stopped loads the buffer into the counter. The counter does not keep its old value.
- R5: A buffer byte written while the timer is stopped appears at once in the same byte of the count.
- R6: Reads return live values at these addresses: address 1 gives count bits 7:0, address 2 gives count bits 15:8 (0 for an 8-bit timer), and address 0 gives the control register.
- R7: Control bits 2:0 select the internal divider: 000 gives /1, 001 gives /2, 010 gives /4 and 011 gives /8. Any code with bit 2 set gives /16. With a buffer of 3, an underflow occurs every 4×divide cycles.
- R8: When control bit 5 is 1, each rising edge on `ext_clk` gives one tick after a two-flop synchronizer, and bits 2:0 have no effect.
- R9: Control register layout: bit 7 is enable, bit 6 is the underflow flag and bit 5 is the source select. After reset the control register reads 0x00, the count reads 0 and `irq` is low.
- R10: A buffer write while the timer runs leaves the current count alone. The new value is used at the next underflow.
- R11: For a 16-bit timer, the low and high buffer bytes are written separately, and a reload takes both bytes as they stand at that moment.
- R12: Writing the control register with bit 6 at 0 clears the flag, unless an underflow happens in the same cycle. Otherwise the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 2 | Register address: 0 control, 1 low byte, 2 high byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| ext_clk | input | 1 | External count clock, asynchronous |
| irq_en | input | 1 | Interrupt enable from a neighbouring register |
| irq | output | 1 | Interrupt request |

## Verification
A register write takes effect at the clock edge that captures it, so the bench drives every write half a cycle early and reads back at the following falling edge. Each enabled edge at divide-by-one moves the count by one. The bench counts edges from the enable write to the stop write or the read, and predicts the exact value: enable, two idle cycles and then stop leaves the count three below its start. Prescaler divisors are found from the cycle gap between two successive flag sets, so the free-running divider phase drops out. External edges pass through three flops before they count, so the bench waits four cycles after the last pulse before it reads.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [1:0] ADDR_CTL = 2'd0;
  localparam logic [1:0] ADDR_LO  = 2'd1;
  localparam logic [1:0] ADDR_HI  = 2'd2;
  localparam int CTL_EN  = 7;
  localparam int CTL_UF  = 6;
  localparam int CTL_SRC = 5;
  localparam int PS_W    = 4;

  // low bits of the free-running divider that must all be one for a tick
  function automatic logic [PS_W-1:0] ps_mask(input logic [2:0] code);
    logic [PS_W-1:0] m;
    if (code[2]) m = '1;
    else begin
      case (code[1:0])
        2'd0:    m = 4'b0000;
        2'd1:    m = 4'b0001;
        2'd2:    m = 4'b0011;
        default: m = 4'b0111;
      endcase
    end
    return m;
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] code,
  output logic       tick
);
  logic [PS_W-1:0] div_q;
  logic [PS_W-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  assign mask = ps_mask(code);
  assign tick = ((div_q & mask) == mask);

  AST_PS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && code != 3'd0 && $stable(code)) |=> !tick); // R7
endmodule

// File: rtl/tmr_extsync.sv
module tmr_extsync (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk,
  output logic tick
);
  logic [2:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[1:0], ext_clk};
  end

  assign tick = sh_q[1] & ~sh_q[2];

  AST_EXT_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R8
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 16,
  localparam int NB = CNT_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             start,
  input  logic             tick,
  input  logic [NB-1:0]    buf_wr,
  input  logic [7:0]       wbyte,
  output logic [CNT_W-1:0] count,
  output logic             uf
);
  logic [CNT_W-1:0] buf_q;
  logic [CNT_W-1:0] cnt_q;

  for (genvar b = 0; b < NB; b++) begin : g_buf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        buf_q[b*8 +: 8] <= '0;
      else if (buf_wr[b]) buf_q[b*8 +: 8] <= wbyte;
    end
  end

  assign uf = en && tick && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start)          cnt_q <= buf_q;
    else if (en && tick)     cnt_q <= (cnt_q == '0) ? buf_q : cnt_q - 1'b1;
    else if (!en) begin
      for (int b = 0; b < NB; b++)
        if (buf_wr[b]) cnt_q[b*8 +: 8] <= wbyte;
    end
  end

  assign count = cnt_q;

  AST_DECR: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && cnt_q != '0 && !start) |=> cnt_q == $past(cnt_q) - 1'b1); // R1
  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !start && buf_wr == '0) |=> $stable(cnt_q)); // R1
  AST_UNDERFLOW_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    uf |=> cnt_q == $past(buf_q)); // R3
  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cnt_q == $past(buf_q)); // R4
endmodule

// File: rtl/tmr_reload_top.sv
module tmr_reload_top
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int NB = CNT_W / 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       ext_clk,
  input  logic       irq_en,
  output logic       irq
);
  logic       en_q, flag_q, src_q;
  logic [2:0] ps_q;
  logic       ctl_wr, start, uf;
  logic       ps_tick, ext_tick, tick;
  logic [NB-1:0]    buf_wr;
  logic [CNT_W-1:0] count;
  logic [15:0]      cnt_pad;

  assign ctl_wr = bus_wr && (bus_addr == ADDR_CTL);
  assign start  = ctl_wr && bus_wdata[CTL_EN] && !en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      flag_q <= 1'b0;
      src_q  <= 1'b0;
      ps_q   <= 3'd0;
    end else begin
      if (ctl_wr) begin
        en_q  <= bus_wdata[CTL_EN];
        src_q <= bus_wdata[CTL_SRC];
        ps_q  <= bus_wdata[2:0];
      end
      if (uf)          flag_q <= 1'b1;
      else if (ctl_wr) flag_q <= flag_q & bus_wdata[CTL_UF];
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bwr
    assign buf_wr[b] = bus_wr && (bus_addr == 2'(b + 1));
  end

  tmr_prescale u_ps (.clk(clk), .rst_n(rst_n), .code(ps_q), .tick(ps_tick));
  tmr_extsync  u_ex (.clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .tick(ext_tick));

  assign tick = src_q ? ext_tick : ps_tick;

  tmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en_q), .start(start), .tick(tick),
    .buf_wr(buf_wr), .wbyte(bus_wdata), .count(count), .uf(uf)
  );

  assign cnt_pad = 16'(count);

  always_comb begin
    case (bus_addr)
      ADDR_CTL: bus_rdata = {en_q, flag_q, src_q, 2'b00, ps_q};
      ADDR_LO:  bus_rdata = cnt_pad[7:0];
      ADDR_HI:  bus_rdata = cnt_pad[15:8];
      default:  bus_rdata = 8'h00;
    endcase
  end

  assign irq = flag_q & irq_en;

  AST_IRQ_ON_UF: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && irq_en) |=> (irq || !irq_en)); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !ctl_wr) |=> flag_q); // R12
endmodule

// File: tb/tb_tmr_reload_top.sv
module tb_tmr_reload_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, ext_clk = 1'b0, irq_en = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic irq;
  int checks = 0, failures = 0, cyc = 0;

  tmr_reload_top #(.CNT_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk(ext_clk),
    .irq_en(irq_en), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
    end
  endtask

  // called just after a falling edge; captured at the next rising edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic rd16(output int v);
    logic [7:0] lo, hi;
    rd(2'd1, lo); rd(2'd2, hi);
    v = {hi, lo};
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] c; int v;
    rd(2'd0, c); check("R9 ctl after reset", c, 8'h00);
    rd16(v);     check("R9 count after reset", v, 0);
    check("R9 irq after reset", irq, 0);
  endtask

  task automatic t_direct;
    int v;
    wr(2'd1, 8'h34); wr(2'd2, 8'h12);
    rd16(v); check("R5 direct write when stopped", v, 16'h1234);
    check("R6 read returns live count", v, 16'h1234);
  endtask

  task automatic t_count;
    int v;
    wr(2'd1, 8'h05); wr(2'd2, 8'h00);
    wr(2'd0, 8'h80);
    rd16(v); check("R4 enable loads buffer", v, 5);
    idle(2);
    wr(2'd0, 8'h00);
    rd16(v); check("R1 three decrements", v, 2);
    idle(5);
    rd16(v); check("R1 stopped count holds", v, 2);
    wr(2'd0, 8'h80);
    rd16(v); check("R4 restart reloads buffer not old count", v, 5);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_underflow;
    int v; logic [7:0] c;
    irq_en = 1'b1;
    wr(2'd1, 8'h03); wr(2'd2, 8'h00);
    wr(2'd0, 8'h80);
    idle(3);
    rd16(v); check("R1 count reaches zero", v, 0);
    rd(2'd0, c); check("R2 no flag before underflow", c[6], 0);
    idle(1);
    rd16(v); check("R3 reload at underflow", v, 3);
    rd(2'd0, c); check("R2 flag set at underflow", c[6], 1);
    check("R2 irq raised", irq, 1);
    irq_en = 1'b0; #1;
    check("R2 irq gated by enable", irq, 0);
    irq_en = 1'b1;
    wr(2'd0, 8'h00);
    rd(2'd0, c); check("R12 flag cleared by writing zero", c[6], 0);
    check("R12 irq drops with flag", irq, 0);
    irq_en = 1'b0;
  endtask

  task automatic t_running_write;
    int v;
    wr(2'd1, 8'h09); wr(2'd2, 8'h00);
    wr(2'd0, 8'h80);
    wr(2'd1, 8'h02);
    wr(2'd2, 8'h01);
    rd16(v); check("R10 running write leaves count", v, 7);
    idle(8);
    rd16(v); check("R11 reload uses both new bytes", v, 16'h0102);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_div(input logic [2:0] code, input int exp);
    logic [7:0] c; int t1 = 0, t2 = 0; string msg;
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h03); wr(2'd2, 8'h00);
    wr(2'd0, 8'h80 | 8'(code));
    for (int i = 0; i < 300; i++) begin
      rd(2'd0, c);
      if (c[6]) begin t1 = cyc; break; end
      @(negedge clk);
    end
    wr(2'd0, 8'h80 | 8'(code));
    for (int i = 0; i < 300; i++) begin
      rd(2'd0, c);
      if (c[6]) begin t2 = cyc; break; end
      @(negedge clk);
    end
    msg = $sformatf("R7 period for code %0d", code);
    check(msg, t2 - t1, exp);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_ext;
    int v;
    wr(2'd1, 8'd10); wr(2'd2, 8'h00);
    wr(2'd0, 8'hA3);
    rd16(v); check("R8 start value with external source", v, 10);
    idle(6);
    rd16(v); check("R8 internal divider ignored", v, 10);
    for (int p = 0; p < 3; p++) begin
      ext_clk = 1'b1; idle(3);
      ext_clk = 1'b0; idle(3);
    end
    idle(4);
    rd16(v); check("R8 one tick per external edge", v, 7);
    wr(2'd0, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_count();
    t_underflow();
    t_running_write();
    t_div(3'd0, 4);
    t_div(3'd1, 8);
    t_div(3'd2, 16);
    t_div(3'd3, 32);
    t_div(3'd4, 64);
    t_div(3'd7, 64);
    t_ext();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule